// File: doc/BRIEF.md
# Service Bus Master Register Bank

This block is the control and status register bank for the master side of a serial service bus. It holds 128 words of 32 bits behind a simple bus with read enable, write enable, a byte address, an access size and write data. Most words keep exactly what software writes. Two port-enable words can also be changed bit by bit through separate set and clear addresses, so that one port can be switched on or off without a read-modify-write.

One command word discards every write made to it. A second command word reinitialises the whole bank when one of its two reset bits is written as 1. A version word is loaded on reset and cannot be overwritten. Any access whose byte address plus access size runs past the end of the bank is harmless: a read returns zero and a write does nothing. Bit fields are numbered big-endian, so field bit 0 is the most significant bit of a word. Reads take one cycle. The link itself, clock division, delay measurement, DMA and parity checking are outside this block.

Top module: `svc_master_regs`

## Requirements
- R1: A write to an ordinary in-range word stores all 32 bits. A read returns the word on `rdata` one clock after the read is sampled, and this includes partially covered last bytes that still fit, such as byte 0x1FF with size 1.
- R2: The enable words at byte offsets 0x010 (enable A) and 0x014 (enable B) take the whole write data when written.
- R3: A write to 0x018 ORs the data into enable A, and a write to 0x01C ORs it into enable B. Data bits that are 0 leave the enable bits unchanged.
- R4: A write to 0x020 clears in enable A every bit that is 1 in the data, and a write to 0x024 does the same for enable B.
- R5: Reads of the set and clear addresses 0x018, 0x01C, 0x020 and 0x024 return zero and never the enable contents.
- R6: Writes to the port-reset command word at 0x0D0 are discarded, and that word always reads zero.
- R7: A write to the bridge-reset word at 0x1D0 with data bit 31 or bit 30 set (big-endian bits 0 and 1) clears every word except the version on the next clock edge. That edge wins over a write sampled on it. A write without those bits changes nothing, and 0x1D0 always reads zero.
- R8: The version word at 0x074 reads 0xE0050101 after any reset, and writes to it are ignored.
- R9: A read with byte address plus size greater than 0x200 returns zero.
- R10: A write with byte address plus size greater than 0x200 modifies no word.
- R11: After hardware reset `rdata` is zero and every word reads zero except the version.
- R12: `rdata` keeps its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, sampled on the clock edge |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| addr | input | 12 | Byte address |
| size | input | 3 | Access size in bytes, 1 to 4 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
A corrupted word stays hidden until something reads it, and the bad value then shows on `rdata` in the cycle after that read. For this reason every random read is compared with a bench model of all 128 words. Mistakes in set or clear merging, or a stray store through an alias, build up in the enable words and appear at the next read of those words. A misrouted soft reset shows up as a non-zero word, or a lost version, two cycles after the triggering write.

// File: rtl/svc_regs_pkg.sv
package svc_regs_pkg;

   // Word indices (byte offset >> 2) whose decode the bank depends on
   localparam int W_EN_A  = 4;
   localparam int W_EN_B  = 5;
   localparam int W_SET_A = 6;
   localparam int W_SET_B = 7;
   localparam int W_CLR_A = 8;
   localparam int W_CLR_B = 9;
   localparam int W_VER   = 29;
   localparam int W_PRST  = 52;
   localparam int W_BRST  = 116;

   typedef enum logic [2:0] {
      ACC_STORE,
      ACC_SET,
      ACC_CLR,
      ACC_DROP,
      ACC_BRST
   } acc_kind_t;

   // Big-endian field bit n of a w-bit word, as an LSB-based position
   function automatic int be_bit(input int n, input int w);
      return w - 1 - n;
   endfunction

endpackage

// File: rtl/svc_access_decode.sv
module svc_access_decode
   import svc_regs_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int SIZE_W    = 3,
   parameter int NUM_WORDS = 128,
   parameter int IDX_W     = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              in_range,
   output logic [IDX_W-1:0]  idx,
   output acc_kind_t         kind,
   output logic [IDX_W-1:0]  tgt
);

   localparam int SPAN_W = ADDR_W + 1;
   localparam logic [SPAN_W-1:0] LIMIT = SPAN_W'(NUM_WORDS * 4);

   logic [SPAN_W-1:0] end_addr;

   always_comb begin
      end_addr = {1'b0, addr} + SPAN_W'(size);
      in_range = (end_addr <= LIMIT);
   end

   assign idx = addr[IDX_W+1:2];

   always_comb begin
      kind = ACC_STORE;
      tgt  = idx;
      case (idx)
         IDX_W'(W_SET_A): begin kind = ACC_SET; tgt = IDX_W'(W_EN_A); end
         IDX_W'(W_SET_B): begin kind = ACC_SET; tgt = IDX_W'(W_EN_B); end
         IDX_W'(W_CLR_A): begin kind = ACC_CLR; tgt = IDX_W'(W_EN_A); end
         IDX_W'(W_CLR_B): begin kind = ACC_CLR; tgt = IDX_W'(W_EN_B); end
         IDX_W'(W_VER):   kind = ACC_DROP;
         IDX_W'(W_PRST):  kind = ACC_DROP;
         IDX_W'(W_BRST):  kind = ACC_BRST;
         default:         kind = ACC_STORE;
      endcase
   end

endmodule

// File: rtl/svc_word_cell.sv
module svc_word_cell #(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_all,
   input  logic              store,
   input  logic              set_bits,
   input  logic              clr_bits,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET_VAL;
      else if (clear_all)
         q <= RESET_VAL;
      else if (store)
         q <= wdata;
      else if (set_bits)
         q <= q | wdata;
      else if (clr_bits)
         q <= q & ~wdata;
   end

endmodule

// File: rtl/svc_read_port.sv
module svc_read_port #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              in_range,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= in_range ? word : '0;
   end

endmodule

// File: rtl/svc_master_regs.sv
module svc_master_regs
   import svc_regs_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 12,
   parameter int                SIZE_W    = 3,
   parameter int                NUM_WORDS = 128,
   parameter logic [DATA_W-1:0] VERSION   = 32'hE005_0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int IDX_W   = $clog2(NUM_WORDS);
   localparam int RST_B0  = be_bit(0, DATA_W);
   localparam int RST_B1  = be_bit(1, DATA_W);

   // Elaboration-time parameter checks
   if ((1 << IDX_W) != NUM_WORDS) begin : g_chk_pow2
      $error("NUM_WORDS must be a power of two");
   end
   if (NUM_WORDS * 4 > (1 << ADDR_W)) begin : g_chk_span
      $error("ADDR_W too narrow for NUM_WORDS");
   end
   if (NUM_WORDS <= W_BRST) begin : g_chk_depth
      $error("NUM_WORDS must cover the bridge-reset word");
   end
   if (DATA_W < 2) begin : g_chk_width
      $error("DATA_W must hold both reset bits");
   end

   logic              in_range;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  tgt;
   acc_kind_t         kind;
   logic              wr_ok;
   logic              brst_pend;
   logic [DATA_W-1:0] words [NUM_WORDS];

   svc_access_decode #(
      .ADDR_W   (ADDR_W),
      .SIZE_W   (SIZE_W),
      .NUM_WORDS(NUM_WORDS),
      .IDX_W    (IDX_W)
   ) u_decode (
      .addr    (addr),
      .size    (size),
      .in_range(in_range),
      .idx     (idx),
      .kind    (kind),
      .tgt     (tgt)
   );

   assign wr_ok = wr_en & in_range;

   // Soft reset applies on the edge after the triggering write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         brst_pend <= 1'b0;
      else
         brst_pend <= wr_ok && (kind == ACC_BRST) &&
                      (wdata[RST_B0] || wdata[RST_B1]);
   end

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam logic [DATA_W-1:0] RV = (i == W_VER) ? VERSION : '0;
      logic st, se, cl;
      assign st = wr_ok && (kind == ACC_STORE) && (idx == IDX_W'(i));
      assign se = wr_ok && (kind == ACC_SET)   && (tgt == IDX_W'(i));
      assign cl = wr_ok && (kind == ACC_CLR)   && (tgt == IDX_W'(i));

      svc_word_cell #(
         .DATA_W   (DATA_W),
         .RESET_VAL(RV)
      ) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear_all(brst_pend),
         .store    (st),
         .set_bits (se),
         .clr_bits (cl),
         .wdata    (wdata),
         .q        (words[i])
      );
   end

   svc_read_port #(
      .DATA_W(DATA_W)
   ) u_read (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .in_range(in_range),
      .word    (words[idx]),
      .rdata   (rdata)
   );

endmodule

// File: rtl/svc_master_regs_chk.sv
module svc_master_regs_chk #(
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 12,
   parameter int                SIZE_W    = 3,
   parameter int                NUM_WORDS = 128,
   parameter logic [DATA_W-1:0] VERSION   = 32'hE005_0101
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [SIZE_W-1:0] size,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata
);

   localparam int SPAN_W = ADDR_W + 1;

   logic              oor;
   logic [ADDR_W-3:0] w;
   logic              en_a_wr_q, brst_wr_q, brst_wr_qq;
   logic [DATA_W-1:0] en_a_data_q;

   assign oor = ({1'b0, addr} + SPAN_W'(size)) > SPAN_W'(NUM_WORDS * 4);
   assign w   = addr[ADDR_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_a_wr_q   <= 1'b0;
         brst_wr_q   <= 1'b0;
         brst_wr_qq  <= 1'b0;
         en_a_data_q <= '0;
      end else begin
         en_a_wr_q   <= wr_en && !oor && (w == (ADDR_W-2)'(4));
         brst_wr_q   <= wr_en && !oor && (w == (ADDR_W-2)'(116));
         brst_wr_qq  <= brst_wr_q;
         en_a_data_q <= wdata;
      end
   end

   AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && oor) |=> (rdata == '0)); // R9

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R12

   AST_PRST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !oor && w == (ADDR_W-2)'(52)) |=> (rdata == '0)); // R6

   AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !oor && w == (ADDR_W-2)'(29)) |=> (rdata == VERSION)); // R8

   AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !oor && w >= (ADDR_W-2)'(6) && w <= (ADDR_W-2)'(9))
      |=> (rdata == '0)); // R5

   AST_ENABLE_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a_wr_q && !brst_wr_qq && rd_en && !oor && w == (ADDR_W-2)'(4))
      |=> (rdata == $past(en_a_data_q))); // R2

endmodule

bind svc_master_regs svc_master_regs_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .SIZE_W   (SIZE_W),
   .NUM_WORDS(NUM_WORDS),
   .VERSION  (VERSION)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .rd_en(rd_en),
   .wr_en(wr_en),
   .addr (addr),
   .size (size),
   .wdata(wdata),
   .rdata(rdata)
);

// File: tb/test_svc_master_regs.sv
module test_svc_master_regs;

   localparam logic [31:0] VER = 32'hE005_0101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [2:0]  size = 3'd4;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] m [128];

   always #2 clk = ~clk;

   svc_master_regs i_svc_master_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_en(rd_en),
      .wr_en(wr_en),
      .addr (addr),
      .size (size),
      .wdata(wdata),
      .rdata(rdata)
   );

   function automatic bit is_oor(input logic [11:0] a, input logic [2:0] s);
      return (int'(a) + int'(s)) > 512;
   endfunction

   function automatic string tag_of(input logic [11:0] a, input logic [2:0] s);
      int i;
      if (is_oor(a, s)) return "R9";
      i = int'(a) >> 2;
      if (i == 4 || i == 5) return "R2";
      if (i >= 6 && i <= 9) return "R5";
      if (i == 52) return "R6";
      if (i == 116) return "R7";
      if (i == 29) return "R8";
      return "R1";
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [2:0] s);
      if (is_oor(a, s)) return 32'h0;
      return m[int'(a) >> 2];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 128; i++) m[i] = 32'h0;
      m[29] = VER;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // Returns 1 when the write starts a soft reset
   function automatic bit model_write(input logic [11:0] a, input logic [2:0] s,
                                      input logic [31:0] d);
      int i;
      if (is_oor(a, s)) return 1'b0;
      i = int'(a) >> 2;
      case (i)
         6:  m[4] = m[4] | d;
         7:  m[5] = m[5] | d;
         8:  m[4] = m[4] & ~d;
         9:  m[5] = m[5] & ~d;
         29, 52: ;
         116: return d[31] | d[30];
         default: m[i] = d;
      endcase
      return 1'b0;
   endfunction

   task automatic do_write(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
      bit trig;
      wr_en = 1'b1; addr = a; size = s; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      trig = model_write(a, s, d);
      if (trig) begin
         @(posedge clk); #1;
         model_reset();
      end
   endtask

   task automatic do_read(input logic [11:0] a, input logic [2:0] s, input string tag);
      rd_en = 1'b1; addr = a; size = s;
      @(posedge clk); #1;
      rd_en = 1'b0;
      check(tag, rdata, exp_read(a, s));
   endtask

   initial begin
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11: reset state
      check("R11", rdata, 32'h0);
      do_read(12'h000, 3'd4, "R11");
      do_read(12'h010, 3'd4, "R11");
      do_read(12'h074, 3'd4, "R11 R8");

      // R1: ordinary store, divider fields at big-endian bits 4-13, 14-23
      do_write(12'h000, 3'd4, 32'h0ABC_DE00);
      do_read(12'h000, 3'd4, "R1");
      do_write(12'h100, 3'd4, 32'h1234_5678);
      do_read(12'h100, 3'd4, "R1");

      // R2..R5: enable A
      do_write(12'h010, 3'd4, 32'hF0F0_0000);
      do_read(12'h010, 3'd4, "R2");
      do_write(12'h018, 3'd4, 32'h0000_000F);
      do_read(12'h010, 3'd4, "R3");
      do_write(12'h020, 3'd4, 32'hF000_0001);
      do_read(12'h010, 3'd4, "R4");
      do_read(12'h018, 3'd4, "R5");
      do_read(12'h020, 3'd4, "R5");

      // R2..R5: enable B
      do_write(12'h014, 3'd4, 32'h0000_FF00);
      do_write(12'h01C, 3'd4, 32'h8000_0000);
      do_read(12'h014, 3'd4, "R3");
      do_write(12'h024, 3'd4, 32'h0000_0F00);
      do_read(12'h014, 3'd4, "R4");
      do_read(12'h01C, 3'd4, "R5");
      do_read(12'h024, 3'd4, "R5");

      // R6, R8: discarded writes
      do_write(12'h0D0, 3'd4, 32'hFFFF_FFFF);
      do_read(12'h0D0, 3'd4, "R6");
      do_write(12'h074, 3'd4, 32'h0000_0000);
      do_read(12'h074, 3'd4, "R8");

      // R9, R10: bank edge
      do_write(12'h1FC, 3'd4, 32'hA5A5_5A5A);
      do_write(12'h1FE, 3'd4, 32'h1111_2222);
      do_read(12'h1FC, 3'd4, "R10");
      do_write(12'h200, 3'd1, 32'h3333_4444);
      do_read(12'h000, 3'd4, "R10");
      do_read(12'h1FD, 3'd4, "R9");
      do_read(12'h200, 3'd1, "R9");
      do_read(12'h1FF, 3'd1, "R1");

      // R12: rdata holds without a read
      held = rdata;
      do_write(12'h040, 3'd4, 32'hDEAD_BEEF);
      @(posedge clk); #1;
      check("R12", rdata, held);

      // R7: bridge reset without and with its trigger bits
      do_write(12'h1D0, 3'd4, 32'h2000_0000);
      do_read(12'h010, 3'd4, "R7");
      do_read(12'h1D0, 3'd4, "R7");
      do_write(12'h1D0, 3'd4, 32'h4000_0000);
      do_read(12'h010, 3'd4, "R7");
      do_read(12'h000, 3'd4, "R7");
      do_read(12'h074, 3'd4, "R7");
      do_write(12'h014, 3'd4, 32'h0000_00F0);
      do_write(12'h1D0, 3'd4, 32'h8000_0000);
      do_read(12'h014, 3'd4, "R7");

      // Random mix
      for (int k = 0; k < 600; k++) begin
         logic [11:0] a;
         logic [2:0]  s;
         int          sel;
         sel = int'($urandom % 10);
         if (sel < 4) begin
            case ($urandom % 10)
               0: a = 12'h010; 1: a = 12'h014; 2: a = 12'h018;
               3: a = 12'h01C; 4: a = 12'h020; 5: a = 12'h024;
               6: a = 12'h074; 7: a = 12'h0D0; 8: a = 12'h1D0;
               default: a = 12'h000;
            endcase
         end else if (sel < 8) begin
            a = 12'($urandom % 512);
         end else begin
            a = 12'($urandom % 1024);
         end
         s = 3'(1 + ($urandom % 4));
         if ($urandom % 2 == 0) begin
            logic [31:0] d;
            d = $urandom;
            if (a == 12'h1D0 && ($urandom % 4) != 0) d[31:30] = 2'b00;
            do_write(a, s, d);
         end else begin
            do_read(a, s, tag_of(a, s));
         end
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule